// File: doc/BRIEF.md
# Fractional Baud-Rate Tick Generator

This block derives the oversampling tick of a serial port from the system clock. A divisor with a 16-bit integer part and a 6-bit fractional part sets the tick period. The fractional part counts in sixty-fourths of a system clock, so the average tick period is the integer part plus the fraction over 64. The oversampling tick runs at sixteen times the bit rate. A second counter divides it by sixteen to give a one-per-bit tick for the transmitter.

Software writes the integer and fractional divisor values into staging registers, which have no effect on their own. A write of the 8-bit line-control value copies both staged divisor parts and the new line-control byte into one 30-bit active register in a single cycle. It then restarts the divider, the fraction accumulator and the bit counter from zero. Integer and fraction may be staged in either order, or only one of them may be changed before the line-control write. An integer divisor of zero parks the generator with no ticks.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the active divisor and `line_ctrl` are zero, and `tick16` and `bit_tick` stay low until a nonzero divisor is loaded.
- R2: A write on `int_wr` or `frac_wr` without `lcr_wr` changes neither `line_ctrl` nor the spacing of `tick16` or `bit_tick`.
- R3: A write on `lcr_wr` loads the staged integer part, the staged fraction and `lcr_wdata` together. `line_ctrl` shows the new byte in the cycle after the write edge. An `int_wr` or `frac_wr` in the same cycle as `lcr_wr` is staged only for a later load.
- R4: Call the cycle after the `lcr_wr` write edge t=0. With integer divisor I ≥ 1, the first `tick16` pulse is high in cycle t = I+1.
- R5: With integer divisor I and fraction F, tick number n (counting from 1) is high in cycle t = 1 + n·I + floor((n−1)·F/64). Every interval is therefore I or I+1 cycles, and the long intervals are spread by a 6-bit accumulator.
- R6: `bit_tick` is high exactly together with every 16th `tick16` pulse, counting from the restart: the 16th, 32nd and so on.
- R7: While the active integer divisor is zero, `tick16` and `bit_tick` stay low whatever the fraction is.
- R8: Every line-control write restarts the divider phase, the fraction accumulator and the bit counter, even in the middle of a period, so R4 to R6 hold again from the new t=0.
- R9: The active divisor is correct for any of these write orders: integer, then fraction, then line control; fraction, then integer, then line control; integer only, then line control; fraction only, then line control. A part that is not rewritten keeps its last staged value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| int_wr | input | 1 | Write strobe for the staged integer divisor |
| int_wdata | input | INT_W (16) | Integer divisor write data |
| frac_wr | input | 1 | Write strobe for the staged fractional divisor |
| frac_wdata | input | FRAC_W (6) | Fractional divisor write data, in units of 1/64 |
| lcr_wr | input | 1 | Line-control write strobe; commits the staged divisor |
| lcr_wdata | input | LCR_W (8) | Line-control write data |
| tick16 | output | 1 | One-cycle pulse at 16 times the bit rate |
| bit_tick | output | 1 | One-cycle pulse on every 16th `tick16` |
| line_ctrl | output | LCR_W (8) | Active line-control byte |

## Verification
The assertions assume that write strobes change only between clock edges and that reset is held from time zero until at least one edge has passed. The stimulus drives every strobe on the falling edge as a single-cycle pulse and holds reset for several cycles at the start. The period and counter-range properties assume the active divisor changes only together with a restart. The bench therefore alters the divisor only through staged writes followed by a line-control write. Where it pokes the staging registers in the middle of a run, it does so without a line-control write and checks that the tick pattern does not move.

// File: rtl/frac_baud_pkg.sv
// Package: frac_baud_pkg
// Holds the default widths shared by the fractional baud-rate generator
// modules. Assumes the oversampling ratio is a power of two.
package frac_baud_pkg;
    localparam int DEF_INT_W  = 16;  // integer divisor width
    localparam int DEF_FRAC_W = 6;   // fractional divisor width (1/64 steps)
    localparam int DEF_LCR_W  = 8;   // line-control byte width
    localparam int DEF_OVS    = 16;  // oversampling ticks per bit
endpackage

// File: rtl/baud_cfg_stage.sv
// Module: baud_cfg_stage
// Staging and active configuration registers. Integer and fraction writes
// land in staging registers only. A line-control write copies both staged
// values and the new line-control byte into the active set in one cycle and
// raises a one-cycle restart. Assumes strobes are synchronous to clk.
module baud_cfg_stage #(
    parameter int INT_W  = frac_baud_pkg::DEF_INT_W,
    parameter int FRAC_W = frac_baud_pkg::DEF_FRAC_W,
    parameter int LCR_W  = frac_baud_pkg::DEF_LCR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              int_wr,
    input  logic [INT_W-1:0]  int_wdata,
    input  logic              frac_wr,
    input  logic [FRAC_W-1:0] frac_wdata,
    input  logic              lcr_wr,
    input  logic [LCR_W-1:0]  lcr_wdata,
    output logic [INT_W-1:0]  act_int,
    output logic [FRAC_W-1:0] act_frac,
    output logic [LCR_W-1:0]  act_lcr,
    output logic              restart
);
    logic [INT_W-1:0]  stg_int;
    logic [FRAC_W-1:0] stg_frac;

    // Capture divisor writes into the staging registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_int  <= '0;
            stg_frac <= '0;
        end else begin
            if (int_wr)  stg_int  <= int_wdata;
            if (frac_wr) stg_frac <= frac_wdata;
        end
    end

    // Commit the combined active register on a line-control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_int  <= '0;
            act_frac <= '0;
            act_lcr  <= '0;
            restart  <= 1'b0;
        end else begin
            restart <= lcr_wr;
            if (lcr_wr) begin
                act_int  <= stg_int;
                act_frac <= stg_frac;
                act_lcr  <= lcr_wdata;
            end
        end
    end

    assert_stage_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lcr_wr |=> ($stable(act_int) && $stable(act_frac) && $stable(act_lcr)));

    assert_lcr_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lcr_wr |=> (act_lcr == $past(lcr_wdata) && restart));
endmodule

// File: rtl/baud_frac_div.sv
// Module: baud_frac_div
// Fractional divider producing the oversampling tick. Each period lasts
// div_int cycles, plus one cycle when the 6-bit fraction accumulator carried
// at the end of the previous period. A restart clears the count, the
// accumulator and the pending extension. A zero integer part parks the
// divider. Assumes div_int and div_frac change only together with restart.
module baud_frac_div #(
    parameter int INT_W  = frac_baud_pkg::DEF_INT_W,
    parameter int FRAC_W = frac_baud_pkg::DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              tick
);
    logic [INT_W-1:0]  cnt;
    logic [FRAC_W-1:0] acc;
    logic              ext_q;
    logic [INT_W:0]    last_cnt;
    logic [FRAC_W:0]   acc_sum;
    logic              at_end;

    // Final count of the current period, widened so I-1+1 cannot wrap.
    always_comb begin
        last_cnt = {1'b0, div_int} - {{INT_W{1'b0}}, 1'b1} + {{INT_W{1'b0}}, ext_q};
        acc_sum  = {1'b0, acc} + {1'b0, div_frac};
        at_end   = ({1'b0, cnt} == last_cnt);
    end

    // Period counter, fraction accumulator and registered tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt   <= '0;
            acc   <= '0;
            ext_q <= 1'b0;
            tick  <= 1'b0;
        end else if (div_int == '0) begin
            cnt   <= '0;
            tick  <= 1'b0;
        end else if (at_end) begin
            cnt   <= '0;
            tick  <= 1'b1;
            acc   <= acc_sum[FRAC_W-1:0];
            ext_q <= acc_sum[FRAC_W];
        end else begin
            cnt   <= cnt + 1'b1;
            tick  <= 1'b0;
        end
    end

    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (div_int == '0) |=> !tick);

    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (div_int != '0 && !restart) |-> (cnt <= div_int));

    assert_tick_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_int > 1 && !restart) |=> !tick);
endmodule

// File: rtl/baud_tick_div.sv
// Module: baud_tick_div
// Divides the oversampling tick by OVS to give the per-bit tick. The bit
// tick coincides with every OVS-th oversampling tick after a restart.
// Assumes OVS is a power of two of at least 2.
module baud_tick_div #(
    parameter int OVS = frac_baud_pkg::DEF_OVS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick16,
    output logic bit_tick
);
    localparam int SUB_W = $clog2(OVS);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

    logic [SUB_W-1:0] sub;

    // Count oversampling ticks within one bit, cleared on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            sub <= '0;
        end else if (tick16) begin
            sub <= (sub == SUB_LAST) ? '0 : sub + 1'b1;
        end
    end

    // Bit tick rides on the last oversampling tick of each bit.
    always_comb bit_tick = tick16 && (sub == SUB_LAST);

    assert_sub_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick16 && !restart) |=> $stable(sub));
endmodule

// File: rtl/frac_baud_gen.sv
// Module: frac_baud_gen
// Top of the fractional baud-rate generator: staged configuration, the
// fractional oversampling divider and the divide-by-OVS bit tick.
// Assumes all write strobes are synchronous single-cycle pulses.
module frac_baud_gen #(
    parameter int INT_W  = frac_baud_pkg::DEF_INT_W,
    parameter int FRAC_W = frac_baud_pkg::DEF_FRAC_W,
    parameter int LCR_W  = frac_baud_pkg::DEF_LCR_W,
    parameter int OVS    = frac_baud_pkg::DEF_OVS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              int_wr,
    input  logic [INT_W-1:0]  int_wdata,
    input  logic              frac_wr,
    input  logic [FRAC_W-1:0] frac_wdata,
    input  logic              lcr_wr,
    input  logic [LCR_W-1:0]  lcr_wdata,
    output logic              tick16,
    output logic              bit_tick,
    output logic [LCR_W-1:0]  line_ctrl
);
    logic [INT_W-1:0]  act_int;
    logic [FRAC_W-1:0] act_frac;
    logic              restart;

    baud_cfg_stage #(.INT_W(INT_W), .FRAC_W(FRAC_W), .LCR_W(LCR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .int_wr(int_wr), .int_wdata(int_wdata),
        .frac_wr(frac_wr), .frac_wdata(frac_wdata),
        .lcr_wr(lcr_wr), .lcr_wdata(lcr_wdata),
        .act_int(act_int), .act_frac(act_frac), .act_lcr(line_ctrl),
        .restart(restart)
    );

    baud_frac_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_div (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .div_int(act_int), .div_frac(act_frac), .tick(tick16)
    );

    baud_tick_div #(.OVS(OVS)) u_bit (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .tick16(tick16), .bit_tick(bit_tick)
    );

    assert_bit_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !restart) |=> !bit_tick);

    assert_restart_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!tick16 && !bit_tick));
endmodule

// File: tb/tb_frac_baud_gen.sv
// Bench: sweeps integer divisors 1..4 against every fraction value, plus a
// few long divisors, comparing each cycle with ticks computed arithmetically.
module tb_frac_baud_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        int_wr = 1'b0;
    logic [15:0] int_wdata = '0;
    logic        frac_wr = 1'b0;
    logic [5:0]  frac_wdata = '0;
    logic        lcr_wr = 1'b0;
    logic [7:0]  lcr_wdata = '0;
    logic        tick16, bit_tick;
    logic [7:0]  line_ctrl;

    int checks = 0;
    int errors = 0;
    int bstg_int = 0;
    int bstg_frac = 0;

    always #5 clk = ~clk;

    frac_baud_gen dut (
        .clk(clk), .rst_n(rst_n),
        .int_wr(int_wr), .int_wdata(int_wdata),
        .frac_wr(frac_wr), .frac_wdata(frac_wdata),
        .lcr_wr(lcr_wr), .lcr_wdata(lcr_wdata),
        .tick16(tick16), .bit_tick(bit_tick), .line_ctrl(line_ctrl)
    );

    function automatic int tick_time(input int ii, input int ff, input int n);
        return 1 + n * ii + ((n - 1) * ff) / 64;
    endfunction

    task automatic wr_int(input int v);
        @(negedge clk); int_wr = 1'b1; int_wdata = 16'(v);
        @(negedge clk); int_wr = 1'b0;
        bstg_int = v;
    endtask

    task automatic wr_frac(input int v);
        @(negedge clk); frac_wr = 1'b1; frac_wdata = 6'(v);
        @(negedge clk); frac_wr = 1'b0;
        bstg_frac = v;
    endtask

    // Writes the line-control byte; returns in cycle t=0 and checks line_ctrl (R3).
    task automatic wr_lcr(input int v);
        @(negedge clk); lcr_wr = 1'b1; lcr_wdata = 8'(v);
        @(posedge clk);
        @(negedge clk); lcr_wr = 1'b0;
        checks++;
        if (line_ctrl !== 8'(v)) begin
            errors++;
            $display("FAIL R3 line_ctrl got %0h exp %0h", line_ctrl, 8'(v));
        end
    endtask

    // Follow cycles t=1..span and compare both ticks with the formula (R4 R5 R6).
    // poke: stage new divisor values at t=2..3 without a commit (R2).
    task automatic follow(input int ii, input int ff, input int ntick, input int lcrv,
                          input bit poke, input string tag);
        int n = 1;
        int next_t = (ii == 0) ? -1 : tick_time(ii, ff, 1);
        int span = (ii == 0) ? 200 : tick_time(ii, ff, ntick) + 2;
        int bad_t = 0, bad_b = 0;
        for (int t = 1; t <= span; t++) begin
            bit exp_t, exp_b;
            if (poke && t == 2) begin int_wr = 1'b1; int_wdata = 16'(ii + 2); bstg_int = ii + 2; end
            if (poke && t == 3) begin int_wr = 1'b0; frac_wr = 1'b1; frac_wdata = 6'(ff ^ 6'h2a); bstg_frac = ff ^ 6'h2a; end
            if (poke && t == 4) frac_wr = 1'b0;
            @(negedge clk);
            exp_t = (t == next_t);
            exp_b = exp_t && (n % 16 == 0);
            if (tick16 !== exp_t && bad_t == 0) begin
                bad_t = 1;
                $display("FAIL %s %s tick16 I=%0d F=%0d t=%0d got %0b exp %0b",
                         (n == 1) ? "R4" : "R5", tag, ii, ff, t, tick16, exp_t);
            end
            if (bit_tick !== exp_b && bad_b == 0) begin
                bad_b = 1;
                $display("FAIL R6 %s bit_tick I=%0d F=%0d t=%0d got %0b exp %0b",
                         tag, ii, ff, t, bit_tick, exp_b);
            end
            if (exp_t) begin n++; next_t = tick_time(ii, ff, n); end
        end
        checks += 2;
        errors += bad_t + bad_b;
        if (poke) begin
            checks++;
            if (line_ctrl !== 8'(lcrv)) begin
                errors++;
                $display("FAIL R2 line_ctrl after staging got %0h exp %0h", line_ctrl, 8'(lcrv));
            end
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state and idle with zero divisor
        checks++;
        if (tick16 !== 1'b0 || bit_tick !== 1'b0 || line_ctrl !== 8'h00) begin
            errors++;
            $display("FAIL R1 reset tick16=%0b bit=%0b lcr=%0h exp 0 0 00", tick16, bit_tick, line_ctrl);
        end
        rst_n = 1'b1;
        begin
            int seen = 0;
            for (int k = 0; k < 100; k++) begin
                @(negedge clk);
                if (tick16 || bit_tick) seen++;
            end
            checks++;
            if (seen != 0) begin
                errors++;
                $display("FAIL R1 ticks after reset got %0d exp 0", seen);
            end
        end
        // R9 order integer then fraction, sweep I=1..4 with every fraction (R5)
        for (int ii = 1; ii <= 4; ii++) begin
            for (int ff = 0; ff < 64; ff++) begin
                wr_int(ii); wr_frac(ff); wr_lcr(ii * 64 + ff);
                follow(ii, ff, 34, ii * 64 + ff, 1'b0, "R9_if");
            end
        end
        // R9 order fraction then integer
        wr_frac(45); wr_int(7); wr_lcr(8'h3c);
        follow(7, 45, 34, 8'h3c, 1'b0, "R9_fi");
        // R2: staged writes mid-run do not disturb the running pattern
        wr_int(5); wr_frac(17); wr_lcr(8'h81);
        follow(5, 17, 20, 8'h81, 1'b1, "R2");
        // R9 fraction only: integer keeps the value staged by the poke (7)
        wr_frac(9); wr_lcr(8'h5a);
        follow(bstg_int, 9, 34, 8'h5a, 1'b0, "R9_f");
        // R9 integer only: fraction keeps 9
        wr_int(300); wr_lcr(8'ha5);
        follow(300, bstg_frac, 34, 8'ha5, 1'b0, "R9_i");
        // R8: reload in the middle of a period restarts phase and bit count
        wr_int(3); wr_frac(50); wr_lcr(8'h11);
        repeat (23) @(negedge clk);
        wr_lcr(8'h12);
        follow(3, 50, 34, 8'h12, 1'b0, "R8");
        // R7: zero integer parks the generator whatever the fraction
        wr_int(0); wr_frac(37); wr_lcr(8'h07);
        follow(0, 37, 0, 8'h07, 1'b0, "R7");
        // R8: leaving zero restarts cleanly
        wr_int(2); wr_lcr(8'h08);
        follow(2, 37, 34, 8'h08, 1'b0, "R8_wake");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired got hang exp finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule